// File: doc/BRIEF.md
# Pseudowire Emulation Packet Framer

This block cuts a continuous client byte stream into fixed-size emulation packets for transport over a packet network. Each packet opens with a 16-byte header made of two parts. The first is a 4-byte control word that carries an attachment-fault flag, a remote-defect flag and a 16-bit sequence number. The second is a 12-byte RTP-format header that carries a payload type, the same sequence number, a timestamp and a source identifier. The client payload follows the header, and its bytes pass through unchanged and in arrival order.

The timestamp comes from an external free-running reference counter. The block samples it, together with the fault and remote-defect inputs, when a packet starts. Payload size, payload type, source identifier and initial sequence number are configuration inputs. The block captures them when it leaves idle on enable, so later changes have no effect until the next enable. When enable drops, the packet in flight is completed and the block then returns to idle. Label and tunnel headers are added further downstream.

Top module: `emu_pkt_framer`

## Requirements
- R1: Header byte 0 is {4'b0000, L, R, 2'b00} (L at bit 3, R at bit 2) and header byte 1 is 0x00.
- R2: Header byte 4 is 0x80 (version 2, all other bits zero). Byte 5 is {1'b0, payload type[6:0]}. Bytes 12..15 carry the source identifier MSB first.
- R3: Bytes 2..3 and bytes 6..7 both carry the packet's 16-bit sequence number MSB first. The number increases by one per packet and wraps from 0xFFFF to 0x0000.
- R4: The first packet after leaving idle carries the initial sequence number presented at that enable.
- R5: Each packet is 16 + payload-size bytes long. Start is flagged on header byte 0 only and last on the final payload byte only. A size of 1024 is supported, and the size must be nonzero.
- R6: Payload bytes are the client bytes, unmodified and in arrival order, with no byte lost or repeated across packet boundaries.
- R7: L equals the fault input sampled at the packet's start edge and holds for the whole packet.
- R8: R equals the remote-defect request sampled at the packet's start edge and holds for the whole packet.
- R9: Bytes 8..11 carry the timestamp input sampled at the packet's start edge, MSB first, and the value holds for the whole packet.
- R10: Configuration changes made while the block is active are ignored until the next enable from idle.
- R11: While out_ready_i is low, a presented byte is held. No client byte is accepted during the header.
- R12: After reset, and after enable drops and the current packet completes, out_valid_o and in_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; sampled at packet boundaries |
| pay_size_i | input | PSZ_W | Payload bytes per packet (nonzero) |
| pt_i | input | 7 | Payload type |
| ssrc_i | input | 32 | Source identifier |
| seq_init_i | input | 16 | Initial sequence number |
| ts_i | input | 32 | Reference timestamp count |
| ac_fault_i | input | 1 | Attachment-fault indication |
| rdi_req_i | input | 1 | Remote-defect request from local receive side |
| in_data_i | input | 8 | Client byte |
| in_valid_i | input | 1 | Client byte valid |
| in_ready_o | output | 1 | Client byte accepted when high with valid |
| out_data_o | output | 8 | Packet byte |
| out_valid_o | output | 1 | Packet byte valid |
| out_ready_i | input | 1 | Downstream ready |
| out_sop_o | output | 1 | First byte of packet |
| out_eop_o | output | 1 | Last byte of packet |

## Verification
The assertions assume that pay_size_i is nonzero at the enable edge where the block leaves idle. They also assume that out_ready_i is free to toggle in any cycle. The payload path is a combinational pass-through, so the stall-hold property is asserted only over header bytes. The bench source keeps in_valid_i and in_data_i steady until a byte is accepted, which extends the hold to payload bytes. Every configured size in the stimulus is at least four. Timestamp and flag inputs change only away from packet-start edges, so the sampled value for each packet is unambiguous.

// File: rtl/emu_pkt_pkg.sv
package emu_pkt_pkg;
  localparam int unsigned HDR_BYTES = 16;
  localparam int unsigned IDX_W     = $clog2(HDR_BYTES);
  localparam int unsigned SEQ_W     = 16;
  localparam int unsigned TS_W      = 32;
  localparam int unsigned ID_W      = 32;
  localparam int unsigned PT_W      = 7;
  localparam logic [7:0]  RTP_LEAD  = 8'h80;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } fr_state_e;
endpackage

// File: rtl/emu_cfg_snap.sv
module emu_cfg_snap
  import emu_pkt_pkg::*;
#(
  parameter int unsigned PSZ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PSZ_W-1:0] size_i,
  input  logic [PT_W-1:0]  pt_i,
  input  logic [ID_W-1:0]  ssrc_i,
  output logic [PSZ_W-1:0] size_o,
  output logic [PT_W-1:0]  pt_o,
  output logic [ID_W-1:0]  ssrc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_o <= '0;
      pt_o   <= '0;
      ssrc_o <= '0;
    end else if (load_i) begin
      size_o <= size_i;
      pt_o   <= pt_i;
      ssrc_o <= ssrc_i;
    end
  end

  // R10: captured configuration only moves at an enable from idle
  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({size_o, pt_o, ssrc_o}));

  // R5: size captured at enable is nonzero
  p_size_nz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> size_i != '0);
endmodule

// File: rtl/emu_seq_gen.sv
module emu_seq_gen
  import emu_pkt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEQ_W-1:0] init_i,
  input  logic             step_i,
  output logic [SEQ_W-1:0] seq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seq_o <= '0;
    else if (load_i) seq_o <= init_i;
    else if (step_i) seq_o <= seq_o + SEQ_W'(1);
  end

  p_seq_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && (seq_o == '1) |=> seq_o == '0);

  p_seq_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> seq_o == $past(init_i));
endmodule

// File: rtl/emu_hdr_mux.sv
module emu_hdr_mux
  import emu_pkt_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic             l_i,
  input  logic             r_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [PT_W-1:0]  pt_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [ID_W-1:0]  ssrc_i,
  output logic [7:0]       byte_o
);
  always_comb begin
    unique case (idx_i)
      4'd0:  byte_o = {4'b0000, l_i, r_i, 2'b00};
      4'd1:  byte_o = 8'h00;
      4'd2:  byte_o = seq_i[15:8];
      4'd3:  byte_o = seq_i[7:0];
      4'd4:  byte_o = RTP_LEAD;
      4'd5:  byte_o = {1'b0, pt_i};
      4'd6:  byte_o = seq_i[15:8];
      4'd7:  byte_o = seq_i[7:0];
      4'd8:  byte_o = ts_i[31:24];
      4'd9:  byte_o = ts_i[23:16];
      4'd10: byte_o = ts_i[15:8];
      4'd11: byte_o = ts_i[7:0];
      4'd12: byte_o = ssrc_i[31:24];
      4'd13: byte_o = ssrc_i[23:16];
      4'd14: byte_o = ssrc_i[15:8];
      default: byte_o = ssrc_i[7:0];
    endcase
  end
endmodule

// File: rtl/emu_pkt_framer.sv
module emu_pkt_framer
  import emu_pkt_pkg::*;
#(
  parameter int unsigned PSZ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSZ_W-1:0] pay_size_i,
  input  logic [PT_W-1:0]  pt_i,
  input  logic [ID_W-1:0]  ssrc_i,
  input  logic [SEQ_W-1:0] seq_init_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             ac_fault_i,
  input  logic             rdi_req_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_sop_o,
  output logic             out_eop_o
);
  localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_BYTES - 1);

  fr_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [PSZ_W-1:0] pay_cnt_q;
  logic             l_q, r_q;
  logic [TS_W-1:0]  ts_q;

  logic [PSZ_W-1:0] cfg_size;
  logic [PT_W-1:0]  cfg_pt;
  logic [ID_W-1:0]  cfg_ssrc;
  logic [SEQ_W-1:0] seq;
  logic [7:0]       hdr_byte;

  logic go_idle, hdr_fire, pay_fire, pay_last, pkt_done, pkt_start;

  assign go_idle   = (state_q == ST_IDLE) && en_i;
  assign hdr_fire  = (state_q == ST_HDR) && out_ready_i;
  assign pay_fire  = (state_q == ST_PAY) && in_valid_i && out_ready_i;
  assign pay_last  = (pay_cnt_q == cfg_size - PSZ_W'(1));
  assign pkt_done  = pay_fire && pay_last;
  assign pkt_start = go_idle || (pkt_done && en_i);

  emu_cfg_snap #(.PSZ_W(PSZ_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go_idle),
    .size_i (pay_size_i),
    .pt_i   (pt_i),
    .ssrc_i (ssrc_i),
    .size_o (cfg_size),
    .pt_o   (cfg_pt),
    .ssrc_o (cfg_ssrc)
  );

  emu_seq_gen u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go_idle),
    .init_i (seq_init_i),
    .step_i (pkt_done),
    .seq_o  (seq)
  );

  emu_hdr_mux u_hdr (
    .idx_i  (idx_q),
    .l_i    (l_q),
    .r_i    (r_q),
    .seq_i  (seq),
    .pt_i   (cfg_pt),
    .ts_i   (ts_q),
    .ssrc_i (cfg_ssrc),
    .byte_o (hdr_byte)
  );

  // per-packet snapshot of timestamp and flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q  <= 1'b0;
      r_q  <= 1'b0;
      ts_q <= '0;
    end else if (pkt_start) begin
      l_q  <= ac_fault_i;
      r_q  <= rdi_req_i;
      ts_q <= ts_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      pay_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (en_i) begin
          state_q <= ST_HDR;
          idx_q   <= '0;
        end
        ST_HDR: if (hdr_fire) begin
          if (idx_q == HDR_LAST) begin
            state_q   <= ST_PAY;
            pay_cnt_q <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_PAY: if (pay_fire) begin
          if (pay_last) begin
            state_q <= en_i ? ST_HDR : ST_IDLE;
            idx_q   <= '0;
          end else begin
            pay_cnt_q <= pay_cnt_q + PSZ_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = in_data_i;
    in_ready_o  = 1'b0;
    if (state_q == ST_HDR) begin
      out_valid_o = 1'b1;
      out_data_o  = hdr_byte;
    end else if (state_q == ST_PAY) begin
      out_valid_o = in_valid_i;
      in_ready_o  = out_ready_i;
    end
  end

  assign out_sop_o = (state_q == ST_HDR) && (idx_q == '0);
  assign out_eop_o = (state_q == ST_PAY) && pay_last;

  p_hdr_no_pull_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR) |-> !in_ready_o);

  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR) && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  p_sop_eop_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_sop_o && out_eop_o));

  p_pay_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAY) |-> pay_cnt_q < cfg_size);

  p_flags_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && !pkt_start |=> $stable({l_q, r_q, ts_q}));

  p_cw_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> (out_data_o[7:4] == 4'h0) && (out_data_o[1:0] == 2'b00));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !out_valid_o && !in_ready_o);
endmodule

// File: tb/emu_pkt_framer_tb.sv
module emu_pkt_framer_tb;
  localparam int CAPN = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] psz = 16'd8;
  logic [6:0]  pt = '0;
  logic [31:0] ssrc = '0;
  logic [15:0] sinit = '0;
  logic [31:0] ts = '0;
  logic        fault = 1'b0;
  logic        rdi = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_sop, out_eop;

  always #5 clk = ~clk;

  emu_pkt_framer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pay_size_i(psz), .pt_i(pt),
    .ssrc_i(ssrc), .seq_init_i(sinit), .ts_i(ts), .ac_fault_i(fault),
    .rdi_req_i(rdi), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_sop_o(out_sop), .out_eop_o(out_eop)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] cap_d [CAPN];
  logic       cap_s [CAPN];
  logic       cap_e [CAPN];
  int cap_n = 0, n_sop = 0, n_eop = 0;
  int sop_at [64];
  int src_cnt = 0;
  bit gap_en = 0, bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  int hold_chk = 0, hold_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // monitor and source
  initial begin
    bit s_fire, pend;
    logic [7:0] hd;
    pend = 0; hd = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        hold_chk++;
        if (!(out_valid && out_data == hd)) hold_bad++;
      end
      pend = out_valid && !out_ready;
      hd = out_data;
      s_fire = in_valid && in_ready;
      if (out_valid && out_ready && cap_n < CAPN) begin
        cap_d[cap_n] = out_data;
        cap_s[cap_n] = out_sop;
        cap_e[cap_n] = out_eop;
        if (out_sop && n_sop < 64) begin sop_at[n_sop] = cap_n; n_sop++; end
        if (out_eop) n_eop++;
        cap_n++;
      end
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (s_fire) begin src_cnt++; in_data = src_cnt[7:0]; end
      in_valid = (in_valid && !s_fire) ? 1'b1 : (!gap_en || lfsr[0]);
      out_ready = !bp_en || lfsr[3];
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_cap(output int base);
    cap_n = 0; n_sop = 0; n_eop = 0;
    base = src_cnt;
  endtask

  task automatic chk_idle(input string tag);
    bit ok = 1;
    repeat (4) begin
      @(negedge clk);
      if (out_valid || in_ready) ok = 0;
    end
    chk(ok, tag, "idle outputs quiet", {out_valid, in_ready}, 0);
    tick();
  endtask

  task automatic run_pkts(input int n);
    int e0 = n_eop;
    en = 1'b1;
    tick();
    while (n_eop < e0 + n - 1) tick();
    en = 1'b0;
    while (n_eop < e0 + n) tick();
    chk_idle("R12");
  endtask

  task automatic chk_pkt(input int k, input int size, input logic [15:0] sq,
                         input bit l, input bit r, input logic [6:0] ptv,
                         input logic [31:0] id, input logic [31:0] tsv, input int base);
    int s = sop_at[k];
    logic [7:0] eh [16];
    bit ok;
    int bad_j;
    eh[0] = {4'b0, l, r, 2'b0}; eh[1] = 8'h00;
    eh[2] = sq[15:8]; eh[3] = sq[7:0];
    eh[4] = 8'h80; eh[5] = {1'b0, ptv};
    eh[6] = sq[15:8]; eh[7] = sq[7:0];
    for (int i = 0; i < 4; i++) begin
      eh[8+i]  = tsv[31-8*i -: 8];
      eh[12+i] = id[31-8*i -: 8];
    end
    chk(k < n_sop, "R5", "packet present", n_sop, k + 1);
    if (k >= n_sop) return;
    chk(cap_d[s] == eh[0], (l ? "R7" : (r ? "R8" : "R1")), "cw byte0 flags", cap_d[s], eh[0]);
    chk(cap_d[s+1] == eh[1], "R1", "cw byte1", cap_d[s+1], eh[1]);
    chk({cap_d[s+2], cap_d[s+3]} == {eh[2], eh[3]}, "R3", "cw seq", {cap_d[s+2], cap_d[s+3]}, sq);
    chk({cap_d[s+6], cap_d[s+7]} == {eh[6], eh[7]}, "R3", "rtp seq", {cap_d[s+6], cap_d[s+7]}, sq);
    chk({cap_d[s+4], cap_d[s+5]} == {eh[4], eh[5]}, "R2", "rtp lead/pt", {cap_d[s+4], cap_d[s+5]}, {eh[4], eh[5]});
    chk({cap_d[s+8], cap_d[s+9], cap_d[s+10], cap_d[s+11]} == tsv, "R9", "timestamp",
        {cap_d[s+8], cap_d[s+9], cap_d[s+10], cap_d[s+11]}, tsv);
    chk({cap_d[s+12], cap_d[s+13], cap_d[s+14], cap_d[s+15]} == id, "R2", "ssrc",
        {cap_d[s+12], cap_d[s+13], cap_d[s+14], cap_d[s+15]}, id);
    // framing marks
    ok = cap_s[s] && cap_e[s+15+size];
    for (int j = s + 1; j < s + 15 + size; j++) if (cap_s[j] || cap_e[j]) ok = 0;
    if (cap_s[s+15+size]) ok = 0;
    chk(ok, "R5", "length/sop/eop", size + 16, size + 16);
    ok = 1; bad_j = 0;
    for (int j = 0; j < size; j++)
      if (cap_d[s+16+j] != 8'(base + k*size + j)) begin ok = 0; bad_j = j; end
    chk(ok, "R6", "payload bytes", cap_d[s+16+bad_j], 8'(base + k*size + bad_j));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(3);
    chk(!out_valid && !in_ready, "R12", "reset outputs", {out_valid, in_ready}, 0);
    rst_n = 1'b1;
    tick(2);
    chk_idle("R12");
  endtask

  task automatic t_basic();
    int b;
    clear_cap(b);
    psz = 16'd8; pt = 7'h61; ssrc = 32'hDEADBEEF; sinit = 16'h1234; ts = 32'h01020304;
    run_pkts(3);
    for (int k = 0; k < 3; k++)
      chk_pkt(k, 8, 16'h1234 + 16'(k), 0, 0, 7'h61, 32'hDEADBEEF, 32'h01020304, b);
    chk(n_eop == 3, "R4", "packet count", n_eop, 3);
  endtask

  task automatic t_wrap();
    int b;
    clear_cap(b);
    psz = 16'd4; pt = 7'h60; ssrc = 32'h0BADF00D; sinit = 16'hFFFE; ts = 32'h11;
    run_pkts(3);
    chk_pkt(0, 4, 16'hFFFE, 0, 0, 7'h60, 32'h0BADF00D, 32'h11, b);
    chk_pkt(1, 4, 16'hFFFF, 0, 0, 7'h60, 32'h0BADF00D, 32'h11, b);
    chk_pkt(2, 4, 16'h0000, 0, 0, 7'h60, 32'h0BADF00D, 32'h11, b);
  endtask

  task automatic t_flags();
    int b;
    clear_cap(b);
    psz = 16'd32; pt = 7'h70; ssrc = 32'h12345678; sinit = 16'h0010;
    ts = 32'hA0A0A0A0; fault = 0; rdi = 0;
    en = 1'b1;
    tick();
    while (cap_n < 10) tick();
    fault = 1; ts = 32'hB1B2B3B4;
    while (!(n_sop >= 2 && cap_n >= sop_at[1] + 20)) tick();
    fault = 0; rdi = 1;
    while (n_eop < 2) tick();
    en = 1'b0;
    while (n_eop < 3) tick();
    chk_idle("R12");
    rdi = 0;
    chk_pkt(0, 32, 16'h0010, 0, 0, 7'h70, 32'h12345678, 32'hA0A0A0A0, b);
    chk_pkt(1, 32, 16'h0011, 1, 0, 7'h70, 32'h12345678, 32'hB1B2B3B4, b);
    chk_pkt(2, 32, 16'h0012, 0, 1, 7'h70, 32'h12345678, 32'hB1B2B3B4, b);
  endtask

  task automatic t_cfg();
    int b;
    clear_cap(b);
    psz = 16'd6; pt = 7'h60; ssrc = 32'hCAFE0001; sinit = 16'h0100; ts = 32'h5;
    en = 1'b1;
    tick();
    while (n_sop < 1) tick();
    psz = 16'd9; pt = 7'h7F; ssrc = 32'hCAFE0002; sinit = 16'h5555;
    while (n_eop < 2) tick();
    en = 1'b0;
    while (n_eop < 3) tick();
    chk_idle("R12");
    for (int k = 0; k < 3; k++)
      chk_pkt(k, 6, 16'h0100 + 16'(k), 0, 0, 7'h60, 32'hCAFE0001, 32'h5, b);
    clear_cap(b);
    run_pkts(2);
    chk_pkt(0, 9, 16'h5555, 0, 0, 7'h7F, 32'hCAFE0002, 32'h5, b);
    chk_pkt(1, 9, 16'h5556, 0, 0, 7'h7F, 32'hCAFE0002, 32'h5, b);
    chk(cap_d[sop_at[0]+3] == 8'h55, "R4", "reload init at enable", cap_d[sop_at[0]+3], 8'h55);
  endtask

  task automatic t_bp();
    int b;
    clear_cap(b);
    hold_chk = 0; hold_bad = 0;
    gap_en = 1; bp_en = 1;
    psz = 16'd12; pt = 7'h66; ssrc = 32'h00C0FFEE; sinit = 16'h7000; ts = 32'h77;
    run_pkts(3);
    gap_en = 0; bp_en = 0;
    tick(2);
    for (int k = 0; k < 3; k++)
      chk_pkt(k, 12, 16'h7000 + 16'(k), 0, 0, 7'h66, 32'h00C0FFEE, 32'h77, b);
    chk(hold_chk > 0, "R11", "stalls exercised", hold_chk, 1);
    chk(hold_bad == 0, "R11", "byte held under stall", hold_bad, 0);
    chk(src_cnt - b == 36, "R11", "client bytes consumed", src_cnt - b, 36);
  endtask

  task automatic t_default();
    int b;
    clear_cap(b);
    psz = 16'd1024; pt = 7'h62; ssrc = 32'h0000ABCD; sinit = 16'h0042; ts = 32'h99;
    run_pkts(1);
    chk(cap_n == 1040, "R5", "default size packet length", cap_n, 1040);
    chk_pkt(0, 1024, 16'h0042, 0, 0, 7'h62, 32'h0000ABCD, 32'h99, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_flags();
    t_cfg();
    t_bp();
    t_default();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule